// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block sequences a small 8-bit microcontroller between three operating modes: run, idle and power-down. Software selects a mode by writing a two-bit power-control register. The block then turns off the CPU clock enable, the peripheral clock enable and the oscillator enable as the mode requires. It also forces the address-latch strobe, the program-store strobe, the port 0 output enable and the port 2 address select to fixed levels for that mode.

In idle, only the CPU clock stops. Any pending interrupt that is also enabled brings the core back, and a one-cycle vector request tells the CPU to enter its service routine. In power-down, everything stops, including the oscillator, and only one wake path exists. An external interrupt pin that is both enabled and set to level-sensitive must be held low, which restarts the oscillator. Once the oscillator reports ready, a programmable number of stable divided-clock steps passes, and a return of the pin to high then completes the exit. While the watchdog runs, power-down requests are dropped.

All state moves on a strobe made by a divide-by-two flip-flop on the input clock. The duty cycle of the input clock therefore does not affect sequencing. An asynchronous active-low reset returns the block to run mode from any mode.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (run), cpu_clk_en_o, per_clk_en_o and osc_en_o are 1, pcon_o is 00 and wake_vec_o is 0. A reset asserted during power-down returns the block to this state.
- R2: A write with bit 0 (idle) set and bit 1 clear moves the block into idle. pcon_o reads 01 and mode_o is 1. cpu_clk_en_o is 0 while per_clk_en_o and osc_en_o stay 1.
- R3: Idle is left only when some bit of irq_pend_i AND irq_en_i is 1. A pending interrupt that is not enabled has no effect. On exit, mode_o returns to 0, pcon_o returns to 00 and wake_vec_o pulses high for exactly one clock.
- R4: With wdt_run_i low, a write with bit 1 (power-down) set enters power-down, even if bit 0 is also set. pcon_o reads 10, mode_o is 2 and all three enables are 0.
- R5: With wdt_run_i high, bit 1 of a write is dropped. A write of 10 leaves the block in run with pcon_o at 00. A write of 11 enters idle with pcon_o at 01.
- R6: In power-down, oscillator restart begins only when some pin k has ext_int_ni[k] low, ext_en_i[k] high and ext_level_i[k] high. osc_en_o then goes to 1 while the CPU and peripheral clocks stay off. A low pin that is disabled or set to edge mode leaves osc_en_o at 0.
- R7: After osc_ready_i, the block waits wake_cnt_i + 1 divided steps. The clocks are released only after that wait, and only once no qualifying pin is low. cpu_clk_en_o then rises between 2*wake_cnt_i+3 and 2*wake_cnt_i+6 clocks after the osc_ready_i pulse when the pin is already high. The exit clears pcon_o to 00 and pulses wake_vec_o once.
- R8: If the qualifying pin returns high before osc_ready_i arrives, the block goes back to full power-down with osc_en_o at 0.
- R9: In run, ale_o and psen_o follow cpu_ale_i and cpu_psen_i. In idle both are 1. In power-down both are 0.
- R10: In run, p0_oe_o and p2_addr_sel_o follow cpu_p0_oe_i and cpu_p2_addr_i. In idle and power-down, p0_oe_o equals NOT ext_prog_i. p2_addr_sel_o is 1 only in idle with ext_prog_i = 1, and is 0 in every other low-power case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, divided by two internally |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pcon_we_i | input | 1 | Power-control write strobe, accepted only in run |
| pcon_wdata_i | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| pcon_o | output | 2 | Current power-control bits |
| wdt_run_i | input | 1 | Watchdog running flag |
| irq_pend_i | input | NIRQ | Interrupt pending flags |
| irq_en_i | input | NIRQ | Interrupt enable flags |
| ext_int_ni | input | NEXT | External interrupt pins, active low |
| ext_en_i | input | NEXT | External interrupt enables |
| ext_level_i | input | NEXT | 1 = level-sensitive, 0 = edge |
| osc_ready_i | input | 1 | Oscillator stable pulse |
| wake_cnt_i | input | CW | Stable-clock steps to wait after oscillator ready |
| ext_prog_i | input | 1 | 1 = program memory is external |
| cpu_ale_i | input | 1 | Address-latch strobe from the CPU |
| cpu_psen_i | input | 1 | Program-store strobe from the CPU |
| cpu_p0_oe_i | input | 1 | Port 0 output enable from the CPU |
| cpu_p2_addr_i | input | 1 | Port 2 address select from the CPU |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| wake_vec_o | output | 1 | One-clock interrupt vector request on wake |
| mode_o | output | 2 | 0 run, 1 idle, 2 power-down |
| ale_o | output | 1 | Address-latch strobe pin level |
| psen_o | output | 1 | Program-store strobe pin level |
| p0_oe_o | output | 1 | Port 0 output enable (0 = float) |
| p2_addr_sel_o | output | 1 | Port 2 drives address when 1 |

## Verification
The bench sweeps the wake delay over several values of wake_cnt_i. A counter that compared against the wrong bound, or that released the clocks before the delay ended, would show up as a rise outside the expected window. It also tries every enable and level combination on both pins. A design that woke on an edge-configured or disabled pin would turn the oscillator on where it must stay off. Other cases cover a pin released before oscillator ready, which must drop back to sleep rather than hang with the oscillator on. They also cover a dual-bit write with the watchdog on and off, where the wrong priority gives the wrong pcon_o readback. Finally, the strobe and port states are checked for both program-memory settings in every mode, so any swapped idle or power-down level shows up as a pin mismatch.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    S_RUN, S_IDLE, S_PD_SLEEP, S_PD_OSC, S_PD_STAB, S_PD_ARMED
  } lpm_state_e;

  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_IDLE = 2'd1,
    M_PD   = 2'd2
  } lpm_mode_e;

  localparam int unsigned PCON_IDLE_BIT = 0;
  localparam int unsigned PCON_PD_BIT   = 1;
endpackage

// File: rtl/lpm_clk_div.sv
module lpm_clk_div (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end

  assign tick_o = half_q;
endmodule

// File: rtl/lpm_pcon.sv
module lpm_pcon
  import lpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  input  logic       wdt_run_i,
  input  logic       clr_i,
  output logic [1:0] q_o
);
  logic [1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (clr_i) begin
      q_d = '0;
    end else if (we_i) begin
      q_d = '0;
      if (wdata_i[PCON_PD_BIT] && !wdt_run_i) q_d[PCON_PD_BIT] = 1'b1;
      else                                    q_d[PCON_IDLE_BIT] = wdata_i[PCON_IDLE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R5
  wdt_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdt_run_i && !clr_i) |=> !q_q[PCON_PD_BIT]);

  // R4
  pd_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdt_run_i && !clr_i && wdata_i == 2'b11) |=> q_q == 2'b10);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [1:0]    pcon_i,
  input  logic          irq_any_i,
  input  logic          pin_wake_i,
  input  logic          osc_ready_i,
  input  logic [CW-1:0] wake_cnt_i,
  output logic          exit_o,
  output logic          wake_vec_o,
  output logic          cpu_clk_en_o,
  output logic          per_clk_en_o,
  output logic          osc_en_o,
  output lpm_mode_e     mode_o
);
  lpm_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_seen_q, vec_q, exit_w, cnt_done;

  assign cnt_done = (cnt_q >= wake_cnt_i);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    exit_w = 1'b0;
    unique case (st_q)
      S_RUN: begin
        if (pcon_i[PCON_PD_BIT])        st_d = S_PD_SLEEP;
        else if (pcon_i[PCON_IDLE_BIT]) st_d = S_IDLE;
      end
      S_IDLE: if (irq_any_i) begin
        st_d   = S_RUN;
        exit_w = 1'b1;
      end
      S_PD_SLEEP: if (pin_wake_i) st_d = S_PD_OSC;
      S_PD_OSC: begin
        if (!pin_wake_i) st_d = S_PD_SLEEP;
        else if (rdy_seen_q) begin
          st_d  = S_PD_STAB;
          cnt_d = '0;
        end
      end
      S_PD_STAB: begin
        if (cnt_done) begin
          if (pin_wake_i) st_d = S_PD_ARMED;
          else begin
            st_d   = S_RUN;
            exit_w = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_PD_ARMED: if (!pin_wake_i) begin
        st_d   = S_RUN;
        exit_w = 1'b1;
      end
      default: st_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_RUN;
      cnt_q      <= '0;
      rdy_seen_q <= 1'b0;
      vec_q      <= 1'b0;
    end else begin
      if (tick_i) begin
        st_q  <= st_d;
        cnt_q <= cnt_d;
      end
      // ready pulse may land between strobes
      rdy_seen_q <= (st_q == S_PD_OSC) && (rdy_seen_q || osc_ready_i);
      vec_q      <= tick_i && exit_w;
    end
  end

  assign exit_o       = tick_i && exit_w;
  assign wake_vec_o   = vec_q;
  assign cpu_clk_en_o = (st_q == S_RUN);
  assign per_clk_en_o = (st_q == S_RUN) || (st_q == S_IDLE);
  assign osc_en_o     = (st_q != S_PD_SLEEP);

  always_comb begin
    unique case (st_q)
      S_RUN:   mode_o = M_RUN;
      S_IDLE:  mode_o = M_IDLE;
      default: mode_o = M_PD;
    endcase
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !irq_any_i) |=> st_q == S_IDLE);

  // R6
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PD_SLEEP && !pin_wake_i) |=> st_q == S_PD_SLEEP);

  // R7
  vec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_q |=> !vec_q);
endmodule

// File: rtl/lpm_pin_mux.sv
module lpm_pin_mux
  import lpm_pkg::*;
(
  input  lpm_mode_e mode_i,
  input  logic      ext_prog_i,
  input  logic      cpu_ale_i,
  input  logic      cpu_psen_i,
  input  logic      cpu_p0_oe_i,
  input  logic      cpu_p2_addr_i,
  output logic      ale_o,
  output logic      psen_o,
  output logic      p0_oe_o,
  output logic      p2_addr_sel_o
);
  always_comb begin
    unique case (mode_i)
      M_IDLE: begin
        ale_o         = 1'b1;
        psen_o        = 1'b1;
        p0_oe_o       = ~ext_prog_i;
        p2_addr_sel_o = ext_prog_i;
      end
      M_PD: begin
        ale_o         = 1'b0;
        psen_o        = 1'b0;
        p0_oe_o       = ~ext_prog_i;
        p2_addr_sel_o = 1'b0;
      end
      default: begin
        ale_o         = cpu_ale_i;
        psen_o        = cpu_psen_i;
        p0_oe_o       = cpu_p0_oe_i;
        p2_addr_sel_o = cpu_p2_addr_i;
      end
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned NIRQ = 5,
  parameter int unsigned NEXT = 2,
  parameter int unsigned CW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pcon_we_i,
  input  logic [1:0]      pcon_wdata_i,
  output logic [1:0]      pcon_o,
  input  logic            wdt_run_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic [NEXT-1:0] ext_int_ni,
  input  logic [NEXT-1:0] ext_en_i,
  input  logic [NEXT-1:0] ext_level_i,
  input  logic            osc_ready_i,
  input  logic [CW-1:0]   wake_cnt_i,
  input  logic            ext_prog_i,
  input  logic            cpu_ale_i,
  input  logic            cpu_psen_i,
  input  logic            cpu_p0_oe_i,
  input  logic            cpu_p2_addr_i,
  output logic            cpu_clk_en_o,
  output logic            per_clk_en_o,
  output logic            osc_en_o,
  output logic            wake_vec_o,
  output logic [1:0]      mode_o,
  output logic            ale_o,
  output logic            psen_o,
  output logic            p0_oe_o,
  output logic            p2_addr_sel_o
);
  logic            tick, exit_w, irq_any, pin_wake;
  logic [NEXT-1:0] pin_qual;
  logic [1:0]      pcon_q;
  lpm_mode_e       mode;

  assign irq_any = |(irq_pend_i & irq_en_i);

  for (genvar k = 0; k < NEXT; k++) begin : g_pin
    assign pin_qual[k] = ~ext_int_ni[k] & ext_en_i[k] & ext_level_i[k];
  end
  assign pin_wake = |pin_qual;

  lpm_clk_div u_div (.clk_i, .rst_ni, .tick_o(tick));

  lpm_pcon u_pcon (
    .clk_i, .rst_ni,
    .we_i     (pcon_we_i && cpu_clk_en_o),
    .wdata_i  (pcon_wdata_i),
    .wdt_run_i,
    .clr_i    (exit_w),
    .q_o      (pcon_q)
  );

  lpm_fsm #(.CW(CW)) u_fsm (
    .clk_i, .rst_ni,
    .tick_i      (tick),
    .pcon_i      (pcon_q),
    .irq_any_i   (irq_any),
    .pin_wake_i  (pin_wake),
    .osc_ready_i,
    .wake_cnt_i,
    .exit_o      (exit_w),
    .wake_vec_o,
    .cpu_clk_en_o,
    .per_clk_en_o,
    .osc_en_o,
    .mode_o      (mode)
  );

  lpm_pin_mux u_mux (
    .mode_i (mode),
    .ext_prog_i, .cpu_ale_i, .cpu_psen_i, .cpu_p0_oe_i, .cpu_p2_addr_i,
    .ale_o, .psen_o, .p0_oe_o, .p2_addr_sel_o
  );

  assign pcon_o = pcon_q;
  assign mode_o = mode;

  // R9
  osc_off_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (!cpu_clk_en_o && !per_clk_en_o && !ale_o && !psen_o));

  // R9
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> (ale_o && psen_o && per_clk_en_o));
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  localparam int NIRQ = 5, NEXT = 2, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pcon_we = 0, wdt_run = 0, osc_ready = 0, ext_prog = 0;
  logic [1:0] pcon_wdata = 0, pcon, mode;
  logic [NIRQ-1:0] irq_pend = 0, irq_en = 0;
  logic [NEXT-1:0] ext_int_n = '1, ext_en = 0, ext_level = 0;
  logic [CW-1:0] wake_cnt = 0;
  logic cpu_ale = 0, cpu_psen = 0, cpu_p0_oe = 0, cpu_p2_addr = 0;
  logic cpu_en, per_en, osc_en, wake_vec, ale, psen, p0_oe, p2_sel;
  int n_chk = 0, n_fail = 0, vec_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  lpm_ctrl #(.NIRQ(NIRQ), .NEXT(NEXT), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pcon_we_i(pcon_we), .pcon_wdata_i(pcon_wdata),
    .pcon_o(pcon), .wdt_run_i(wdt_run), .irq_pend_i(irq_pend), .irq_en_i(irq_en),
    .ext_int_ni(ext_int_n), .ext_en_i(ext_en), .ext_level_i(ext_level),
    .osc_ready_i(osc_ready), .wake_cnt_i(wake_cnt), .ext_prog_i(ext_prog),
    .cpu_ale_i(cpu_ale), .cpu_psen_i(cpu_psen), .cpu_p0_oe_i(cpu_p0_oe),
    .cpu_p2_addr_i(cpu_p2_addr), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .osc_en_o(osc_en), .wake_vec_o(wake_vec), .mode_o(mode), .ale_o(ale),
    .psen_o(psen), .p0_oe_o(p0_oe), .p2_addr_sel_o(p2_sel)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wake_vec) vec_cnt <= vec_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] v);
    @(negedge clk);
    pcon_we = 1; pcon_wdata = v;
    @(negedge clk);
    pcon_we = 0;
    clks(4);
  endtask

  // state vector {mode, cpu, per, osc}
  function automatic int st();
    return {mode, cpu_en, per_en, osc_en};
  endfunction

  task automatic idle_wake(input int idx, input string req);
    int v0;
    v0 = vec_cnt;
    irq_en = 0; irq_pend = 0;
    irq_pend[idx] = 1;
    clks(8);
    chk({req, " pend-only ignored"}, mode, 1);
    irq_en[idx] = 1;
    clks(4);
    chk({req, " idle exit mode"}, st(), {2'd0, 3'b111});
    chk({req, " idle exit pcon"}, pcon, 0);
    chk({req, " one vector pulse"}, vec_cnt - v0, 1);
    irq_en = 0; irq_pend = 0;
    clks(2);
  endtask

  task automatic pd_wake(input int w, input int pin);
    int k, v0;
    v0 = vec_cnt;
    wake_cnt = w[CW-1:0];
    ext_en = 0; ext_level = 0; ext_int_n = '1;
    ext_en[pin] = 1; ext_level[pin] = 1;
    ext_int_n[pin] = 0;
    clks(4);
    chk("R6 osc restarts on level pin", st(), {2'd2, 3'b001});
    osc_ready = 1;
    @(negedge clk);
    osc_ready = 0;
    k = 1;
    while (k < 3) begin @(negedge clk); k++; end
    ext_int_n[pin] = 1;
    while (!cpu_en && k < 200) begin @(negedge clk); k++; end
    n_chk++;
    if (k < 2*w + 3 || k > 2*w + 6) begin
      n_fail++;
      $display("FAIL R7 release delay w=%0d actual=%0d expected=%0d..%0d", w, k, 2*w+3, 2*w+6);
    end
    clks(2);
    chk("R7 pcon cleared", pcon, 0);
    chk("R7 one vector pulse", vec_cnt - v0, 1);
    chk("R7 run restored", st(), {2'd0, 3'b111});
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    clks(3);
    rst_n = 1;
    clks(2);
    chk("R1 reset state", st(), {2'd0, 3'b111});
    chk("R1 reset pcon", pcon, 0);
    chk("R1 reset vec", wake_vec, 0);

    // run-mode pass-through sweep
    for (int p = 0; p < 16; p++) begin
      {cpu_ale, cpu_psen, cpu_p0_oe, cpu_p2_addr} = p[3:0];
      #1;
      chk("R9/R10 run pass-through", {ale, psen, p0_oe, p2_sel}, p);
    end

    // idle per interrupt line and memory setting
    for (int e = 0; e < 2; e++) begin
      ext_prog = e[0];
      for (int i = 0; i < NIRQ; i++) begin
        wr(2'b01);
        chk("R2 idle state", st(), {2'd1, 3'b011});
        chk("R2 idle pcon", pcon, 1);
        chk("R9 idle strobes", {ale, psen}, 3);
        chk("R10 idle ports", {p0_oe, p2_sel}, {~e[0], e[0]});
        idle_wake(i, "R3");
      end
    end

    // power-down wake sweep over delays and pins
    for (int e = 0; e < 2; e++) begin
      ext_prog = e[0];
      for (int w = 0; w < 6; w++) begin
        wr((w % 2 == 0) ? 2'b10 : 2'b11);
        chk("R4 pd state", st(), {2'd2, 3'b000});
        chk("R4 pd pcon", pcon, 2);
        chk("R9 pd strobes", {ale, psen}, 0);
        chk("R10 pd ports", {p0_oe, p2_sel}, {~e[0], 1'b0});
        pd_wake(w, w % 2);
      end
    end

    // non-qualifying pin configurations
    wr(2'b10);
    for (int pin = 0; pin < NEXT; pin++) begin
      for (int c = 0; c < 3; c++) begin
        ext_en = 0; ext_level = 0; ext_int_n = '1;
        ext_en[pin] = c[0]; ext_level[pin] = c[1];
        ext_int_n[pin] = 0;
        clks(6);
        chk("R6 unqualified pin ignored", st(), {2'd2, 3'b000});
      end
    end
    ext_int_n = '1;

    // pin released before oscillator ready
    ext_en = 2'b01; ext_level = 2'b01; ext_int_n = 2'b10;
    clks(4);
    chk("R8 osc on while low", osc_en, 1);
    ext_int_n = 2'b11;
    clks(4);
    chk("R8 back to sleep", st(), {2'd2, 3'b000});

    // pin held low beyond the delay: stay gated until release
    wake_cnt = 2;
    ext_int_n = 2'b10;
    clks(4);
    osc_ready = 1; @(negedge clk); osc_ready = 0;
    clks(20);
    chk("R7 held until pin high", st(), {2'd2, 3'b001});
    ext_int_n = 2'b11;
    clks(4);
    chk("R7 released on pin high", st(), {2'd0, 3'b111});
    chk("R7 pcon cleared", pcon, 0);

    // watchdog running
    wdt_run = 1;
    wr(2'b10);
    chk("R5 pd dropped state", st(), {2'd0, 3'b111});
    chk("R5 pd dropped pcon", pcon, 0);
    wr(2'b11);
    chk("R5 dual write gives idle", pcon, 1);
    chk("R5 idle state", st(), {2'd1, 3'b011});
    idle_wake(2, "R5");
    wdt_run = 0;

    // reset during power-down
    wr(2'b10);
    chk("R4 pd before reset", mode, 2);
    @(negedge clk); rst_n = 0;
    clks(2);
    chk("R1 reset from pd", st(), {2'd0, 3'b111});
    chk("R1 reset pcon", pcon, 0);
    rst_n = 1;
    clks(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule